// File: doc/BRIEF.md
# Coprocessor Shared-RAM Host Window

This block sits between a host processor and the local RAM of an I/O coprocessor. The host sees four byte-wide registers. Two of them load a RAM pointer one byte at a time, one is a data window onto the RAM byte the pointer selects, and one is a status/control byte. With the step mode on, every data access moves the pointer forward by one, so a whole block of RAM can be streamed after loading the pointer once. The coprocessor reaches the same RAM through its own port. In this project the coprocessor is modelled by the testbench through that port.

The status/control byte carries the coprocessor run enable, the step-mode enable, a peripheral pass-through enable and a doorbell bit that sends a single pulse to the coprocessor. It also holds two event flags that only the coprocessor can raise. The host clears an event flag by writing the byte back with that flag's bit set. Either pending flag drives the single host interrupt line. A liveness convention is carried entirely in RAM: the coprocessor stores 0xFF in an agreed byte, and the host checks it and writes it back to zero.

Top module: `copro_ram_port`

## Requirements
- R1: After reset the pointer is 0x0000, every status/control bit is 0, and host_irq, cp_run, cp_irq and periph_bypass are all low.
- R2: Writing host_sel=0 loads pointer bits 7:0 and writing host_sel=1 loads pointer bits 15:8. Reading either select returns that pointer byte.
- R3: A host read (host_rd high for one cycle, host_wr low) puts the selected value on host_rdata from the next clock edge on, and host_rdata holds until the next read. Selecting host_sel=2 reads or writes the RAM byte at the pointer. The RAM is indexed by the low MEM_AW pointer bits. When host_rd and host_wr are both high, only the write takes place.
- R4: With AUTOINC (status/control bit 1) set, every data access, read or write, advances the pointer by one after the access. With AUTOINC clear, the pointer is unchanged by data accesses.
- R5: The pointer wraps from 0xFFFF to 0x0000 when it advances.
- R6: A host write to host_sel=3 sets RUN (bit 0, drives cp_run), AUTOINC (bit 1) and BYPASS (bit 5, drives periph_bypass) to the written values. Reading select 3 returns {2'b00, BYPASS, IRQ, INT1, INT0, AUTOINC, RUN}.
- R7: A status/control write with bit 4 (IRQ) set raises cp_irq for exactly the following cycle. Otherwise cp_irq stays low.
- R8: A one-cycle pulse on cp_set_int0 or cp_set_int1 sets INT0 (bit 2) or INT1 (bit 3). host_irq is high whenever either flag is set.
- R9: A status/control write with bit 2 or bit 3 set clears that flag, and writing 0 to the bit leaves the flag unchanged. When a set and a clear of the same flag arrive in the same cycle, the flag stays set.
- R10: The coprocessor port writes RAM with cp_we and returns the byte at cp_addr on cp_rdata one cycle later. Bytes written by either side are visible to the other, which carries the 0xFF-then-clear liveness check.
- R11: When host and coprocessor write the same RAM byte in the same cycle, the host data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 status/control |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid from the edge after host_rd |
| host_irq | output | 1 | Host interrupt, set while INT0 or INT1 is pending |
| cp_we | input | 1 | Coprocessor RAM write enable |
| cp_addr | input | MEM_AW | Coprocessor RAM address |
| cp_wdata | input | 8 | Coprocessor RAM write data |
| cp_rdata | output | 8 | Coprocessor RAM read data, one cycle latency |
| cp_set_int0 | input | 1 | Coprocessor raises INT0 |
| cp_set_int1 | input | 1 | Coprocessor raises INT1 |
| cp_run | output | 1 | Coprocessor run enable |
| cp_irq | output | 1 | One-cycle doorbell pulse to the coprocessor |
| periph_bypass | output | 1 | Peripheral pass-through enable |

## Verification
The bench uses the default parameters: a 16-bit pointer over a 256-byte RAM. With these values the full pointer wrap at 0xFFFF can be reached, and the RAM aliases every 256 addresses. The bench first fills the whole RAM through the streaming window, so every random data read afterwards has a known expected value. Random mixes of pointer loads, data accesses with step mode on and off, control writes, flag raises and coprocessor RAM traffic are compared against a bench model. Directed cases cover the wrap, the doorbell pulse width, a flag set and clear arriving together, a write collision on the same byte, and the liveness handshake.

// File: rtl/copro_pkg.sv
package copro_pkg;

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    localparam int BIT_RUN  = 0;
    localparam int BIT_AINC = 1;
    localparam int BIT_INT0 = 2;
    localparam int BIT_INT1 = 3;
    localparam int BIT_IRQ  = 4;
    localparam int BIT_BYP  = 5;

    typedef struct packed {
        logic run;
        logic ainc;
        logic int0;
        logic int1;
        logic irq;
        logic byp;
    } ctrl_s;

endpackage

// File: rtl/copro_addr_ptr.sv
module copro_addr_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          step,
    input  logic [7:0]    wdata,
    output logic [AW-1:0] addr
);
    localparam int HI_W = AW - 8;

    typedef struct packed {
        logic [AW-1:0] addr;
    } ptr_s;

    ptr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo) begin
            st_d.addr[7:0] = wdata;
        end else if (ld_hi) begin
            st_d.addr[AW-1:8] = wdata[HI_W-1:0];
        end else if (step) begin
            st_d.addr = st_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.addr;

    // R4 / R5: an access in step mode moves the pointer by exactly one, modulo 2**AW
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=> (st_q.addr == AW'($past(st_q.addr) + AW'(1))));

    // R4: without a load or a step the pointer holds
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_lo && !ld_hi) |=> $stable(st_q.addr));

    // R2: a low-byte load lands in bits 7:0
    assert_ptr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (st_q.addr[7:0] == $past(wdata)));

endmodule

// File: rtl/copro_ctrl_reg.sv
module copro_ctrl_reg
    import copro_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       set0,
    input  logic       set1,
    output ctrl_s      ctrl
);
    ctrl_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_ctrl) begin
            st_d.run  = wdata[BIT_RUN];
            st_d.ainc = wdata[BIT_AINC];
            st_d.byp  = wdata[BIT_BYP];
            st_d.irq  = wdata[BIT_IRQ];
            if (wdata[BIT_INT0]) st_d.int0 = 1'b0;
            if (wdata[BIT_INT1]) st_d.int1 = 1'b0;
        end
        if (set0) st_d.int0 = 1'b1;
        if (set1) st_d.int1 = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q;

    // R7: the doorbell is only ever high right after a control write that asked for it
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(wr_ctrl && wdata[BIT_IRQ]));

    // R7: the doorbell never lasts past one cycle without a new request
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !(wr_ctrl && wdata[BIT_IRQ])) |=> !st_q.irq);

    // R9: a raise always wins
    assert_int0_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set0 |=> st_q.int0);
    assert_int1_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set1 |=> st_q.int1);

    // R9: write-one clears when no raise competes
    assert_int0_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[BIT_INT0] && !set0) |=> !st_q.int0);

    // R8: flags only rise through a coprocessor raise
    assert_int0_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.int0) |-> $past(set0));

endmodule

// File: rtl/copro_dpram.sv
module copro_dpram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] a_rdata_q;
    logic [DW-1:0] b_rdata_q;

    // port A is written last so it wins a same-address collision (R11)
    always_ff @(posedge clk) begin
        if (b_we) mem_q[b_addr] <= b_wdata;
        if (a_we) mem_q[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata_q <= '0;
            b_rdata_q <= '0;
        end else begin
            if (a_re) a_rdata_q <= mem_q[a_addr];
            b_rdata_q <= mem_q[b_addr];
        end
    end

    assign a_rdata = a_rdata_q;
    assign b_rdata = b_rdata_q;

    // R3: the host-side read register only moves on a read
    assert_ram_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_rdata_q));

endmodule

// File: rtl/copro_ram_port.sv
module copro_ram_port
    import copro_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_irq,
    input  logic              cp_we,
    input  logic [MEM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic [7:0]        cp_rdata,
    input  logic              cp_set_int0,
    input  logic              cp_set_int1,
    output logic              cp_run,
    output logic              cp_irq,
    output logic              periph_bypass
);
    reg_sel_e            sel;
    logic                rd_eff;
    logic                data_acc;
    logic                step;
    logic [ADDR_W-1:0]   addr;
    logic [15:0]         addr_ext;
    ctrl_s               ctrl;
    logic [7:0]          ctrl_byte;
    logic [7:0]          ram_rdata;

    typedef struct packed {
        logic       from_ram;
        logic [7:0] val;
    } rd_s;

    rd_s rd_d, rd_q;

    assign sel      = reg_sel_e'(host_sel);
    assign rd_eff   = host_rd && !host_wr;
    assign data_acc = (host_wr || rd_eff) && (sel == SEL_DATA);
    assign step     = data_acc && ctrl.ainc;
    assign addr_ext = 16'(addr);

    copro_addr_ptr #(.AW(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (host_wr && sel == SEL_PTR_LO),
        .ld_hi (host_wr && sel == SEL_PTR_HI),
        .step  (step),
        .wdata (host_wdata),
        .addr  (addr)
    );

    copro_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (host_wr && sel == SEL_CTRL),
        .wdata   (host_wdata),
        .set0    (cp_set_int0),
        .set1    (cp_set_int1),
        .ctrl    (ctrl)
    );

    copro_dpram #(.AW(MEM_AW), .DW(8)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (host_wr && sel == SEL_DATA),
        .a_re    (rd_eff && sel == SEL_DATA),
        .a_addr  (addr[MEM_AW-1:0]),
        .a_wdata (host_wdata),
        .a_rdata (ram_rdata),
        .b_we    (cp_we),
        .b_addr  (cp_addr),
        .b_wdata (cp_wdata),
        .b_rdata (cp_rdata)
    );

    assign ctrl_byte = {2'b00, ctrl.byp, ctrl.irq, ctrl.int1, ctrl.int0, ctrl.ainc, ctrl.run};

    always_comb begin
        rd_d = rd_q;
        if (rd_eff) begin
            rd_d.from_ram = (sel == SEL_DATA);
            case (sel)
                SEL_PTR_LO: rd_d.val = addr_ext[7:0];
                SEL_PTR_HI: rd_d.val = addr_ext[15:8];
                SEL_CTRL:   rd_d.val = ctrl_byte;
                default:    rd_d.val = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata    = rd_q.from_ram ? ram_rdata : rd_q.val;
    assign host_irq      = ctrl.int0 || ctrl.int1;
    assign cp_run        = ctrl.run;
    assign cp_irq        = ctrl.irq;
    assign periph_bypass = ctrl.byp;

    // R3: host_rdata holds between reads
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    // R6: run output follows a control write
    assert_run_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel == SEL_CTRL) |=> (cp_run == $past(host_wdata[BIT_RUN])));

    // R8: the host line only drops after a control write
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_irq) |-> $past(host_wr && sel == SEL_CTRL));

endmodule

// File: tb/tb_copro_ram_port.sv
module tb_copro_ram_port;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 8;
    localparam int DEPTH      = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        host_sel = '0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              host_irq;
    logic              cp_we = 1'b0;
    logic [MEM_AW-1:0] cp_addr = '0;
    logic [7:0]        cp_wdata = '0;
    logic [7:0]        cp_rdata;
    logic              cp_set_int0 = 1'b0;
    logic              cp_set_int1 = 1'b0;
    logic              cp_run;
    logic              cp_irq;
    logic              periph_bypass;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [7:0]  m_mem [DEPTH];
    logic [15:0] m_addr = '0;
    logic        m_run = 0, m_ainc = 0, m_byp = 0, m_int0 = 0, m_int1 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    copro_ram_port #(.ADDR_W(16), .MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .cp_we(cp_we), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_set_int0(cp_set_int0),
        .cp_set_int1(cp_set_int1), .cp_run(cp_run), .cp_irq(cp_irq),
        .periph_bypass(periph_bypass)
    );

    function automatic logic [7:0] exp_ctrl();
        return {2'b00, m_byp, 1'b0, m_int1, m_int0, m_ainc, m_run};
    endfunction

    function automatic logic [15:0] next_addr(input logic [15:0] a);
        return a + 16'd1;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        case (s)
            2'd0: m_addr[7:0]  = d;
            2'd1: m_addr[15:8] = d;
            2'd2: begin
                m_mem[m_addr[MEM_AW-1:0]] = d;
                if (m_ainc) m_addr = next_addr(m_addr);
            end
            default: begin
                m_run = d[0]; m_ainc = d[1]; m_byp = d[5];
                if (d[2]) m_int0 = 1'b0;
                if (d[3]) m_int1 = 1'b0;
            end
        endcase
    endtask

    task automatic hread(input logic [1:0] s, output logic [7:0] v, output logic [7:0] e);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        case (s)
            2'd0: e = m_addr[7:0];
            2'd1: e = m_addr[15:8];
            2'd2: begin
                e = m_mem[m_addr[MEM_AW-1:0]];
                if (m_ainc) m_addr = next_addr(m_addr);
            end
            default: e = exp_ctrl();
        endcase
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic cp_write(input logic [MEM_AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cp_addr = a; cp_wdata = d; cp_we = 1'b1;
        @(negedge clk);
        cp_we = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic cp_read(input logic [MEM_AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        cp_addr = a;
        @(negedge clk);
        v = cp_rdata;
    endtask

    task automatic raise(input logic s0, input logic s1);
        @(negedge clk);
        cp_set_int0 = s0; cp_set_int1 = s1;
        @(negedge clk);
        cp_set_int0 = 1'b0; cp_set_int1 = 1'b0;
        if (s0) m_int0 = 1'b1;
        if (s1) m_int1 = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, e;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 host_irq", 16'(host_irq), 16'd0);
        check("R1 cp_run", 16'(cp_run), 16'd0);
        check("R1 cp_irq", 16'(cp_irq), 16'd0);
        check("R1 periph_bypass", 16'(periph_bypass), 16'd0);
        hread(2'd3, v, e); check("R1 ctrl", 16'(v), 16'h00);
        hread(2'd0, v, e); check("R1 ptr lo", 16'(v), 16'h00);
        hread(2'd1, v, e); check("R1 ptr hi", 16'(v), 16'h00);

        // R4 stream fill of the whole RAM with step mode on
        hwrite(2'd3, 8'h02);
        check("R6 cp_run after ainc only", 16'(cp_run), 16'd0);
        for (int i = 0; i < DEPTH; i++) hwrite(2'd2, 8'(i * 7 + 3));
        hread(2'd0, v, e); check("R4 ptr lo after fill", 16'(v), 16'(e));
        hread(2'd1, v, e); check("R4 ptr hi after fill", 16'(v), 16'h01);

        // R4 step off: repeated reads stay on the same byte
        hwrite(2'd0, 8'h10); hwrite(2'd1, 8'h00);
        hwrite(2'd3, 8'h00);
        hread(2'd2, v, e); check("R3 data read", 16'(v), 16'(e));
        hread(2'd2, v, e); check("R4 no-step reread", 16'(v), 16'(e));
        hread(2'd0, v, e); check("R4 ptr unchanged", 16'(v), 16'h10);

        // R3 rd and wr together: write only
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 8'hC3; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        m_mem[8'h10] = 8'hC3;
        hread(2'd2, v, e); check("R3 wr-over-rd", 16'(v), 16'hC3);

        // R5 wrap
        hwrite(2'd3, 8'h02);
        hwrite(2'd0, 8'hFF); hwrite(2'd1, 8'hFF);
        hwrite(2'd2, 8'h5A);
        hread(2'd0, v, e); check("R5 wrap lo", 16'(v), 16'h00);
        hread(2'd1, v, e); check("R5 wrap hi", 16'(v), 16'h00);
        hwrite(2'd0, 8'hFF); hwrite(2'd1, 8'h00);
        hread(2'd2, v, e); check("R5 wrap data at alias", 16'(v), 16'h5A);

        // R6 run / bypass
        hwrite(2'd3, 8'h23);
        check("R6 cp_run", 16'(cp_run), 16'd1);
        check("R6 periph_bypass", 16'(periph_bypass), 16'd1);
        hread(2'd3, v, e); check("R6 ctrl readback", 16'(v), 16'h23);

        // R7 doorbell: high for exactly one cycle
        hwrite(2'd3, 8'h13);
        check("R7 cp_irq pulse", 16'(cp_irq), 16'd1);
        @(negedge clk);
        check("R7 cp_irq ends", 16'(cp_irq), 16'd0);

        // R8 flags
        raise(1'b1, 1'b0);
        check("R8 host_irq int0", 16'(host_irq), 16'd1);
        raise(1'b0, 1'b1);
        hread(2'd3, v, e); check("R8 ctrl both flags", 16'(v), 16'(e));
        // R9 write 0 leaves, write 1 clears
        hwrite(2'd3, 8'h03);
        check("R9 zero keeps", 16'(host_irq), 16'd1);
        hwrite(2'd3, 8'h07);
        hread(2'd3, v, e); check("R9 int0 cleared", 16'(v), 16'h0B);
        hwrite(2'd3, 8'h0B);
        check("R9 both cleared host_irq", 16'(host_irq), 16'd0);
        // R9 set wins over clear
        raise(1'b1, 1'b0);
        @(negedge clk);
        host_sel = 2'd3; host_wdata = 8'h07; host_wr = 1'b1; cp_set_int0 = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cp_set_int0 = 1'b0;
        m_run = 1'b1; m_ainc = 1'b1; m_byp = 1'b0; m_int0 = 1'b1;
        check("R9 set wins", 16'(host_irq), 16'd1);
        hwrite(2'd3, 8'h07);

        // R10 liveness handshake
        cp_write(8'h40, 8'hFF);
        hwrite(2'd3, 8'h01);
        hwrite(2'd0, 8'h40); hwrite(2'd1, 8'h00);
        hread(2'd2, v, e); check("R10 alive byte", 16'(v), 16'hFF);
        hwrite(2'd2, 8'h00);
        cp_read(8'h40, v); check("R10 alive cleared", 16'(v), 16'h00);

        // R11 collision: host wins
        hwrite(2'd0, 8'h55);
        @(negedge clk);
        host_sel = 2'd2; host_wdata = 8'hA1; host_wr = 1'b1;
        cp_addr = 8'h55; cp_wdata = 8'h1E; cp_we = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cp_we = 1'b0;
        m_mem[8'h55] = 8'hA1;
        cp_read(8'h55, v); check("R11 host wins", 16'(v), 16'hA1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            case ($urandom % 9)
                0: hwrite(2'd0, r);
                1: hwrite(2'd1, r);
                2: hwrite(2'd2, r);
                3: begin hread(2'd2, v, e); check("R3 random data read", 16'(v), 16'(e)); end
                4: begin hread(2'(($urandom % 2)), v, e); check("R2 random ptr read", 16'(v), 16'(e)); end
                5: begin
                    hwrite(2'd3, r & 8'h3F);
                    check("R7 random doorbell", 16'(cp_irq), 16'(r[4]));
                    check("R6 random run", 16'(cp_run), 16'(m_run));
                end
                6: raise(r[0], r[1]);
                7: cp_write(MEM_AW'($urandom), r);
                default: begin
                    logic [MEM_AW-1:0] a;
                    a = MEM_AW'($urandom);
                    cp_read(a, v); check("R10 random cp read", 16'(v), 16'(m_mem[a]));
                end
            endcase
            check("R8 random host_irq", 16'(host_irq), 16'(m_int0 | m_int1));
        end
        hread(2'd3, v, e); check("R6 final ctrl", 16'(v), 16'(e));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule